// File: doc/BRIEF.md
# Multiplexed-Address Memory Controller with Periodic Refresh

This block sits between a simple request/acknowledge CPU bus and a dynamic memory whose address pins are shared between a row half and a column half. When the bus asks for a read or a write, the controller latches the whole address and the write data. It places the row half on the shared memory address port and pulls the active-low row strobe low. It then places the column half on the port and pulls the active-low column strobe low. It finishes with one precharge cycle, in which the bus is acknowledged.

A free-running interval counter raises a refresh request each time it wraps. A pending refresh is served before any bus request, including one that arrives in the same cycle. The refresh lowers the column strobe first and the row strobe one cycle later. While a refresh is pending or any operation is in progress, a busy output tells the bus master that its request is being held off.

Top module: `mxa_dram_ctrl`

## Requirements
- R1: After reset, memRasN, memCasN and memWeN are high, busAck is low and busBusy is low.
- R2: The address and write data are captured in the cycle a request is accepted. Later changes on busAddr or busWdata do not alter that access.
- R3: A request seen by the controller while idle, with no refresh pending, is accepted at that clock edge. In the next cycle memRasN=0 and memCasN=1, with memAddr holding the row field busAddr[ROW_W+COL_W-1:COL_W]. In the cycle after that, both strobes are 0 and memAddr holds the column field busAddr[COL_W-1:0]. For a read, memWeN stays high throughout.
- R4: For a write, memWeN is 0 in the column cycle only, and memWdata carries the captured data, so the memory stores it at {row, column}.
- R5: busAck is high for exactly one cycle, the third cycle after acceptance. Both strobes are high in that cycle. For a read, busRdata holds the data returned in the column cycle from then until the next read.
- R6: A refresh request is raised every REF_INTERVAL cycles. With the bus idle, the first refresh starts REF_INTERVAL+1 cycles after reset is released, and later refreshes start exactly REF_INTERVAL cycles apart.
- R7: A refresh drives memCasN=0 with memRasN=1 for one cycle, then both low for one cycle, then both high.
- R8: A pending refresh wins over a bus request presented in the same cycle. busBusy is high while a refresh is pending or the controller is not idle. The held request is served after the refresh, and busAck follows 7 cycles after the request was presented.
- R9: Every operation ends with a cycle in which both strobes are high, and the row strobe never rises while the column strobe stays low.
- R10: memAddr is max(ROW_W, COL_W) bits wide, and the shorter field is zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busReq | input | 1 | Request, held high until busAck |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | ROW_W+COL_W | Bus address (row field on top) |
| busWdata | input | DATA_W | Write data |
| busAck | output | 1 | One-cycle completion pulse |
| busBusy | output | 1 | Controller cannot accept a request now |
| busRdata | output | DATA_W | Last read data |
| memAddr | output | max(ROW_W,COL_W) | Shared row/column address |
| memRasN | output | 1 | Row strobe, active low |
| memCasN | output | 1 | Column strobe, active low |
| memWeN | output | 1 | Write enable, active low |
| memWdata | output | DATA_W | Data to memory |
| memRdata | input | DATA_W | Data from memory, sampled at the end of the column cycle |

## Verification
When the bench presents a request while busBusy is low, it expects the row cycle at the very next falling-edge sample. The column cycle is due one cycle after that and busAck one cycle later again, because each of the three states is a single registered step. The first refresh is due at the 65th sample after reset release, and each later one 64 samples after the previous start. The collision test presents a request in the sample right after the counter wraps and expects the refresh pattern next, then busAck seven samples after the request. Every sample is taken on the falling edge, so strobes and the address, which change at the rising edge, are read half a cycle after they settle.

// File: rtl/mxa_pkg.sv
package mxa_pkg;
  typedef struct packed {
    logic loadReq;
    logic selCol;
    logic loadRd;
  } dpStrobe_t;

  typedef enum logic [2:0] {
    S_IDLE, S_ROW, S_COL, S_ACK, S_RCAS, S_RRAS, S_RPRE
  } seqState_t;
endpackage

// File: rtl/mxa_refresh_timer.sv
module mxa_refresh_timer #(
  parameter int REF_INTERVAL = 64
) (
  input  logic clk,
  input  logic rstN,
  output logic refTick
);
  localparam int CNT_W = (REF_INTERVAL > 2) ? $clog2(REF_INTERVAL) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(REF_INTERVAL - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign refTick = (cnt == LAST);

  // R6: a request is a single-cycle event between wraps
  a_r6_tick_single: assert property (@(posedge clk) disable iff (!rstN)
    refTick |=> !refTick);
endmodule

// File: rtl/mxa_datapath.sv
module mxa_datapath
  import mxa_pkg::*;
#(
  parameter int ROW_W  = 8,
  parameter int COL_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic clk,
  input  logic rstN,
  input  dpStrobe_t strobes,
  input  logic [ROW_W+COL_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] busRdata
);
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int MA_W = (ROW_W > COL_W) ? ROW_W : COL_W;

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] wdataReg;
  logic [DATA_W-1:0] rdataReg;
  logic [ROW_W-1:0] rowPart;
  logic [COL_W-1:0] colPart;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg  <= '0;
      wdataReg <= '0;
      rdataReg <= '0;
    end else begin
      if (strobes.loadReq) begin
        addrReg  <= busAddr;
        wdataReg <= busWdata;
      end
      if (strobes.loadRd) rdataReg <= memRdata;
    end
  end

  assign rowPart  = addrReg[ADDR_W-1:COL_W];
  assign colPart  = addrReg[COL_W-1:0];
  assign memAddr  = strobes.selCol ? MA_W'(colPart) : MA_W'(rowPart);
  assign memWdata = wdataReg;
  assign busRdata = rdataReg;

  // R2: captured address only changes when the control accepts a request
  a_r2_addr_held: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadReq |=> $stable(addrReg));
endmodule

// File: rtl/mxa_control.sv
module mxa_control
  import mxa_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic busReq,
  input  logic busWe,
  input  logic refTick,
  output dpStrobe_t strobes,
  output logic busAck,
  output logic busBusy,
  output logic memRasN,
  output logic memCasN,
  output logic memWeN
);
  seqState_t state, nextState;
  logic refPending;
  logic writeReg;

  always_comb begin
    nextState = state;
    case (state)
      S_IDLE: begin
        if (refPending) nextState = S_RCAS;
        else if (busReq) nextState = S_ROW;
      end
      S_ROW:  nextState = S_COL;
      S_COL:  nextState = S_ACK;
      S_ACK:  nextState = S_IDLE;
      S_RCAS: nextState = S_RRAS;
      S_RRAS: nextState = S_RPRE;
      S_RPRE: nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      refPending <= 1'b0;
      writeReg   <= 1'b0;
    end else begin
      state <= nextState;
      if (refTick) refPending <= 1'b1;
      else if (state == S_IDLE) refPending <= 1'b0;
      if (strobes.loadReq) writeReg <= busWe;
    end
  end

  always_comb begin
    strobes.loadReq = (state == S_IDLE) && !refPending && busReq;
    strobes.selCol  = (state == S_COL);
    strobes.loadRd  = (state == S_COL) && !writeReg;
  end

  assign memRasN = !((state == S_ROW) || (state == S_COL) || (state == S_RRAS));
  assign memCasN = !((state == S_COL) || (state == S_RCAS) || (state == S_RRAS));
  assign memWeN  = !((state == S_COL) && writeReg);
  assign busAck  = (state == S_ACK);
  assign busBusy = (state != S_IDLE) || refPending;

  // R5: acknowledge is a single pulse
  a_r5_ack_pulse: assert property (@(posedge clk) disable iff (!rstN)
    busAck |=> !busAck);
  // R5: acknowledge only answers a request that was presented
  a_r5_ack_has_req: assert property (@(posedge clk) disable iff (!rstN)
    busAck |-> $past(busReq, 3));
endmodule

// File: rtl/mxa_dram_ctrl.sv
module mxa_dram_ctrl
  import mxa_pkg::*;
#(
  parameter int ROW_W        = 8,
  parameter int COL_W        = 8,
  parameter int DATA_W       = 16,
  parameter int REF_INTERVAL = 64
) (
  input  logic clk,
  input  logic rstN,
  input  logic busReq,
  input  logic busWe,
  input  logic [ROW_W+COL_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic busAck,
  output logic busBusy,
  output logic [DATA_W-1:0] busRdata,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] memAddr,
  output logic memRasN,
  output logic memCasN,
  output logic memWeN,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata
);
  dpStrobe_t strobes;
  logic refTick;

  mxa_refresh_timer #(.REF_INTERVAL(REF_INTERVAL)) uTimer (
    .clk(clk), .rstN(rstN), .refTick(refTick)
  );

  mxa_control uCtrl (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWe(busWe),
    .refTick(refTick), .strobes(strobes), .busAck(busAck),
    .busBusy(busBusy), .memRasN(memRasN), .memCasN(memCasN),
    .memWeN(memWeN)
  );

  mxa_datapath #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busAddr(busAddr),
    .busWdata(busWdata), .memRdata(memRdata), .memAddr(memAddr),
    .memWdata(memWdata), .busRdata(busRdata)
  );

  // R3: in an access the column strobe only falls with the row strobe already low
  a_r3_cas_after_ras: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(memCasN) && !memRasN) |-> $past(!memRasN));
  // R7: in a refresh the row strobe falls with the column strobe already low
  a_r7_ras_after_cas: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(memRasN) && !memCasN) |-> $past(!memCasN));
  // R9: strobes release together into a precharge cycle
  a_r9_precharge: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memRasN) |-> memCasN);
  // R4: write enable is only active with both strobes low
  a_r4_we_in_col: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (!memRasN && !memCasN));
endmodule

// File: tb/tb_mxa_dram_ctrl.sv
module tb_mxa_dram_ctrl;
  localparam int ROW_W = 6;
  localparam int COL_W = 5;
  localparam int DATA_W = 16;
  localparam int REF_INTERVAL = 64;
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int MA_W = (ROW_W > COL_W) ? ROW_W : COL_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busReq = 1'b0;
  logic busWe = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [DATA_W-1:0] busWdata = '0;
  logic busAck, busBusy;
  logic [DATA_W-1:0] busRdata;
  logic [MA_W-1:0] memAddr;
  logic memRasN, memCasN, memWeN;
  logic [DATA_W-1:0] memWdata;
  logic [DATA_W-1:0] memRdata = '0;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  mxa_dram_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
                  .REF_INTERVAL(REF_INTERVAL)) dut (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busAck(busAck),
    .busBusy(busBusy), .busRdata(busRdata), .memAddr(memAddr),
    .memRasN(memRasN), .memCasN(memCasN), .memWeN(memWeN),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  // behavioural memory: row latched on row-strobe fall, column on column-strobe fall
  logic [DATA_W-1:0] mem [0:(1<<ADDR_W)-1];
  logic [ROW_W-1:0] rowLatch = '0;
  logic prevRas = 1'b1, prevCas = 1'b1;
  initial for (int i = 0; i < (1 << ADDR_W); i++) mem[i] = '0;

  always @(negedge clk) begin
    if (rstN) begin
      if (prevRas && !memRasN && memCasN) rowLatch = memAddr[ROW_W-1:0];
      if (prevCas && !memCasN && !memRasN && !prevRas) begin
        if (!memWeN) mem[{rowLatch, memAddr[COL_W-1:0]}] = memWdata;
        else memRdata = mem[{rowLatch, memAddr[COL_W-1:0]}];
      end
    end
    prevRas = memRasN;
    prevCas = memCasN;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic t_reset();
    @(negedge clk);
    chk(memRasN && memCasN && memWeN, "R1", "strobes idle", {memRasN, memCasN, memWeN}, 3'b111);
    chk(!busAck && !busBusy, "R1", "ack/busy low", {busAck, busBusy}, 2'b00);
    rstN = 1'b1;
  endtask

  // waits for a refresh start; returns samples waited
  task automatic wait_refresh(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(memRasN && !memCasN) && n < 1000);
  endtask

  task automatic check_refresh_tail();
    chk(busBusy, "R8", "busy in refresh", busBusy, 1);
    @(negedge clk);
    chk(!memRasN && !memCasN, "R7", "both low second cycle", {memRasN, memCasN}, 2'b00);
    @(negedge clk);
    chk(memRasN && memCasN, "R9", "precharge after refresh", {memRasN, memCasN}, 2'b11);
  endtask

  task automatic t_refresh_timing();
    int n;
    wait_refresh(n);
    chk(n == REF_INTERVAL + 1, "R6", "first refresh delay", n, REF_INTERVAL + 1);
    chk(memRasN, "R7", "ras high while cas low", memRasN, 1);
    check_refresh_tail();
    wait_refresh(n);
    chk(n + 2 == REF_INTERVAL, "R6", "refresh spacing", n + 2, REF_INTERVAL);
    check_refresh_tail();
  endtask

  // assumes the last sample was two cycles after a refresh start
  task automatic t_collision(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] expD);
    int n;
    for (int i = 0; i < REF_INTERVAL - 3; i++) @(negedge clk);
    chk(busBusy, "R8", "busy with pending refresh", busBusy, 1);
    busReq = 1'b1; busWe = 1'b0; busAddr = a;
    @(negedge clk);
    chk(!memCasN && memRasN, "R8", "refresh wins", {memRasN, memCasN}, 2'b10);
    n = 1;
    while (!busAck && n < 20) begin @(negedge clk); n++; end
    chk(n == 7, "R8", "ack delay after held request", n, 7);
    chk(busRdata == expD, "R8", "held read data", busRdata, expD);
    busReq = 1'b0;
  endtask

  task automatic t_access(input bit we, input logic [ADDR_W-1:0] a,
                          input logic [DATA_W-1:0] d, input logic [DATA_W-1:0] expD);
    int n;
    bit freeBefore;
    @(negedge clk);
    freeBefore = !busBusy;
    busReq = 1'b1; busWe = we; busAddr = a; busWdata = d;
    n = 0;
    do begin @(negedge clk); n++; end while (!(!memRasN && memCasN) && n < 200);
    if (freeBefore) chk(n == 1, "R3", "accept latency", n, 1);
    chk(memAddr == MA_W'(a[ADDR_W-1:COL_W]), "R10", "row on port", memAddr, a[ADDR_W-1:COL_W]);
    chk(memWeN, "R3", "we high in row cycle", memWeN, 1);
    busAddr = ~a; busWdata = ~d;
    @(negedge clk);
    chk(!memRasN && !memCasN, "R3", "column cycle strobes", {memRasN, memCasN}, 2'b00);
    chk(memAddr == MA_W'(a[COL_W-1:0]), "R2", "column after bus change", memAddr, a[COL_W-1:0]);
    chk(memWeN == !we, we ? "R4" : "R3", "write enable", memWeN, !we);
    if (we) chk(memWdata == d, "R4", "write data", memWdata, d);
    @(negedge clk);
    chk(busAck && memRasN && memCasN, "R5", "ack in precharge", {busAck, memRasN, memCasN}, 3'b111);
    if (!we) chk(busRdata == expD, "R5", "read data", busRdata, expD);
    busReq = 1'b0;
    @(negedge clk);
    chk(!busAck, "R5", "ack one cycle", busAck, 0);
    if (!we) chk(busRdata == expD, "R5", "read data held", busRdata, expD);
    if (we) chk(mem[a] == d, "R4", "memory content", mem[a], d);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_refresh_timing();
    t_collision(11'h000, 16'h0000);
    t_access(1'b1, 11'h000, 16'h1234, '0);
    t_access(1'b1, 11'h7FF, 16'hBEEF, '0);
    t_access(1'b1, 11'h2A5, 16'hA5A5, '0);
    t_access(1'b1, 11'h2BA, 16'h5A5A, '0);
    t_access(1'b0, 11'h2A5, '0, 16'hA5A5);
    t_access(1'b0, 11'h000, '0, 16'h1234);
    t_access(1'b0, 11'h7FF, '0, 16'hBEEF);
    t_access(1'b0, 11'h2BA, '0, 16'h5A5A);
    t_access(1'b1, 11'h2A5, 16'h0F0F, '0);
    t_access(1'b0, 11'h2A5, '0, 16'h0F0F);
    for (int k = 0; k < 40; k++)
      t_access(1'b1, ADDR_W'(k * 37), DATA_W'(k * 515 + 7), '0);
    for (int k = 0; k < 40; k++)
      t_access(1'b0, ADDR_W'(k * 37), '0, DATA_W'(k * 515 + 7));
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule